// File: doc/BRIEF.md
# Block Floating Point Pass Normalizer

This block handles the block floating point scaling of a transform that runs as several passes over the same data. During each pass it looks at every valid complex result and counts the redundant sign bits of the real and the imaginary parts. It keeps the smallest count seen in the pass, which belongs to the largest-magnitude value. When a pass that is not the last one ends, it turns that count into a left-shift amount. The datapath applies this shift to every sample before the next pass, so the largest value fills the word again.

The shift for one pass is limited to four. The sum of all shifts over one transform is limited to what a 4-bit exponent can report. The growth mode decides that limit. With 3-bit word growth, overflow cannot happen and all sixteen exponent codes are shift counts. With 2-bit word growth, the total stops at 14 and code 15 is kept to mean that an overflow occurred. In that case a sticky flag also tells the output stage to zero every frequency bin. When the last pass ends, a one-cycle done strobe is raised together with the final exponent.

Top module: `bfp_pass_norm`

## Requirements
- R1: After reset, shift_o, exp_o, done_o and ovf_o are all 0.
- R2: For a 16-bit value, the redundant sign count is the number of bits directly below the MSB that are equal to the MSB. It runs from 0 up to 15 (15 for the values 0 and -1). The tracker keeps the minimum of this count over the real and imaginary parts of every sample that has res_vld_i=1. It restarts at each pass_start_i. Samples with res_vld_i=0 have no effect.
- R3: A pass_start_i with first_i=1 sets shift_o to 0. One cycle after a pass_end_i with last_i=0, shift_o shows min(tracked count, 4, cap minus running total). shift_o then holds that value until the next pass end.
- R4: The running total is the sum of all shifts issued since the first pass started. The cap is 15 when mode_i=1 (3-bit growth) and 14 when mode_i=0 (2-bit growth). The mode is captured at the first pass start.
- R5: One cycle after a pass_end_i with last_i=1, done_o is high for exactly one cycle. At that point exp_o shows the running total, and it holds that value until the next done.
- R6: In 2-bit mode, an ovf_i seen while a transform is active sets ovf_o from the next cycle until the next first pass start. The final exp_o of that transform is then 15.
- R7: In 3-bit mode, ovf_i has no effect: ovf_o stays 0 and exp_o reports the shift total.
- R8: A pass with no valid samples counts as 15 sign bits, so its shift is set only by the per-pass and total limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Growth mode: 0 = 2-bit (cap 14, code 15 = overflow), 1 = 3-bit (cap 15) |
| pass_start_i | input | 1 | Strobe at the start of a pass |
| first_i | input | 1 | Marks the start strobe of the first pass of a transform |
| pass_end_i | input | 1 | Strobe at the end of a pass (the sample on this cycle still counts) |
| last_i | input | 1 | Marks the end strobe of the final pass |
| res_vld_i | input | 1 | Result sample valid |
| res_re_i | input | 16 | Real part of result, two's complement |
| res_im_i | input | 16 | Imaginary part of result, two's complement |
| ovf_i | input | 1 | Overflow indication from the datapath |
| shift_o | output | 3 | Left shift to apply before the next pass |
| exp_o | output | 4 | Final exponent / overflow code |
| done_o | output | 1 | One-cycle strobe when the final exponent is valid |
| ovf_o | output | 1 | Sticky overflow flag: force all output bins to zero |

## Verification
A pass with data of mixed magnitudes shows that the largest magnitude wins, and that a real part and an imaginary part can each set the minimum. A non-valid full-scale sample, placed between small samples, shows that invalid data is ignored. Runs of empty passes in both modes drive the shift into the per-pass limit first and then into the total limit. They separate cap 15 from cap 14 and show the partial last shift. Overflow pulses in each mode separate the reserved code and the sticky flag from the mode where overflow is ignored.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic {
    GROW2 = 1'b0,
    GROW3 = 1'b1
  } grow_e;
endpackage

// File: rtl/bfp_sign_cnt.sv
module bfp_sign_cnt #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_comb begin
    cnt = '0;
    run = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (val_i[i] == val_i[DATA_W-1])) cnt = cnt + ONE;
      else run = 1'b0;
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/bfp_min_track.sv
module bfp_min_track #(
  parameter int DATA_W = 16,
  parameter int SB_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] re_i,
  input  logic [DATA_W-1:0] im_i,
  output logic [SB_W-1:0]   min_o
);
  localparam logic [SB_W-1:0] SB_MAX = SB_W'(DATA_W - 1);

  logic [1:0][DATA_W-1:0] part;
  logic [1:0][SB_W-1:0]   cnt;
  logic [SB_W-1:0]        cnt_min;
  logic [SB_W-1:0]        min_q;

  assign part = {im_i, re_i};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    bfp_sign_cnt #(.DATA_W(DATA_W), .CNT_W(SB_W)) i_cnt (
      .val_i(part[g]),
      .cnt_o(cnt[g])
    );
  end

  assign cnt_min = (cnt[0] < cnt[1]) ? cnt[0] : cnt[1];

  // includes the sample present on the current cycle
  always_comb begin
    min_o = min_q;
    if (vld_i && (cnt_min < min_q)) min_o = cnt_min;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= SB_MAX;
    end else if (start_i) begin
      min_q <= vld_i ? cnt_min : SB_MAX;
    end else if (vld_i && (cnt_min < min_q)) begin
      min_q <= cnt_min;
    end
  end

  // R2
  min_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !start_i) |=> (min_q <= $past(cnt_min)));
  // R8
  empty_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !vld_i) |=> (min_q == SB_MAX));
endmodule

// File: rtl/bfp_shift_ctrl.sv
module bfp_shift_ctrl
  import bfp_pkg::*;
#(
  parameter int SB_W      = 4,
  parameter int SHIFT_MAX = 4,
  parameter int SHIFT_W   = $clog2(SHIFT_MAX + 1),
  parameter int EXP_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               start_i,
  input  logic               first_i,
  input  logic               end_i,
  input  logic               last_i,
  input  logic               ovf_i,
  input  logic [SB_W-1:0]    min_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               done_o,
  output logic               ovf_o
);
  localparam int CW = (SB_W > EXP_W) ? SB_W : EXP_W;
  localparam logic [CW-1:0]    CAP_FULL = CW'((1 << EXP_W) - 1);
  localparam logic [CW-1:0]    CAP_RSV  = CAP_FULL - CW'(1);
  localparam logic [CW-1:0]    LIM      = CW'(SHIFT_MAX);
  localparam logic [EXP_W-1:0] EXP_TOP  = '1;

  grow_e              mode_q;
  logic               busy_q, done_q, ovf_q;
  logic [EXP_W-1:0]   total_q, exp_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [CW-1:0]      cap, budget, step;
  logic               ovf_hit;

  always_comb begin
    cap    = (mode_q == GROW3) ? CAP_FULL : CAP_RSV;
    budget = cap - CW'(total_q);
    step   = CW'(min_i);
    if (step > LIM)    step = LIM;
    if (step > budget) step = budget;
  end

  assign ovf_hit = busy_q && ovf_i && (mode_q == GROW2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= GROW2;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      total_q <= '0;
      exp_q   <= '0;
      shift_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && first_i) begin
        busy_q  <= 1'b1;
        mode_q  <= grow_e'(mode_i);
        total_q <= '0;
        shift_q <= '0;
        ovf_q   <= 1'b0;
      end else if (ovf_hit) begin
        ovf_q <= 1'b1;
      end
      if (end_i && busy_q) begin
        if (last_i) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          exp_q  <= (ovf_q || ovf_hit) ? EXP_TOP : total_q;
        end else begin
          shift_q <= step[SHIFT_W-1:0];
          total_q <= total_q + step[EXP_W-1:0];
        end
      end
    end
  end

  assign shift_o = shift_q;
  assign exp_o   = exp_q;
  assign done_o  = done_q;
  assign ovf_o   = ovf_q;

  // R3
  shift_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(shift_q) <= LIM);
  // R4
  total_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == GROW2) |-> (CW'(total_q) <= CAP_RSV));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  ovf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && ovf_q) |-> (exp_q == EXP_TOP));
  // R7
  wide_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == GROW3) |-> !ovf_q);
endmodule

// File: rtl/bfp_pass_norm.sv
module bfp_pass_norm #(
  parameter int DATA_W    = 16,
  parameter int SHIFT_MAX = 4,
  parameter int EXP_W     = 4,
  localparam int SB_W     = $clog2(DATA_W),
  localparam int SHIFT_W  = $clog2(SHIFT_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               pass_start_i,
  input  logic               first_i,
  input  logic               pass_end_i,
  input  logic               last_i,
  input  logic               res_vld_i,
  input  logic [DATA_W-1:0]  res_re_i,
  input  logic [DATA_W-1:0]  res_im_i,
  input  logic               ovf_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               done_o,
  output logic               ovf_o
);
  logic [SB_W-1:0] min_now;

  bfp_min_track #(.DATA_W(DATA_W), .SB_W(SB_W)) i_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pass_start_i),
    .vld_i  (res_vld_i),
    .re_i   (res_re_i),
    .im_i   (res_im_i),
    .min_o  (min_now)
  );

  bfp_shift_ctrl #(
    .SB_W(SB_W), .SHIFT_MAX(SHIFT_MAX), .SHIFT_W(SHIFT_W), .EXP_W(EXP_W)
  ) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .start_i(pass_start_i),
    .first_i(first_i),
    .end_i  (pass_end_i),
    .last_i (last_i),
    .ovf_i  (ovf_i),
    .min_i  (min_now),
    .shift_o(shift_o),
    .exp_o  (exp_o),
    .done_o (done_o),
    .ovf_o  (ovf_o)
  );
endmodule

// File: tb/test_bfp_pass_norm.sv
module test_bfp_pass_norm;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b0, ps = 1'b0, fst = 1'b0, pe = 1'b0, lst = 1'b0;
  logic        vld = 1'b0, ovf = 1'b0;
  logic [15:0] re = '0, im = '0;
  logic [2:0]  shift_o;
  logic [3:0]  exp_o;
  logic        done_o, ovf_o;

  int checks = 0, errors = 0, cycles = 0;
  int m_min = 15, m_shift = 0, m_total = 0, m_exp = 0;
  bit m_done = 0, m_ovf = 0, m_busy = 0, m_mode = 0;

  always #(CLK_P/2) clk = ~clk;

  bfp_pass_norm i_bfp_pass_norm (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .pass_start_i(ps), .first_i(fst),
    .pass_end_i(pe), .last_i(lst), .res_vld_i(vld), .res_re_i(re), .res_im_i(im),
    .ovf_i(ovf), .shift_o(shift_o), .exp_o(exp_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  function automatic int sc(input logic [15:0] v);
    int x = $signed(v);
    int n = 0;
    while (n < 15 && x >= -(1 << (14 - n)) && x < (1 << (14 - n))) n++;
    return n;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_min = 15; m_shift = 0; m_total = 0; m_exp = 0;
      m_done = 0; m_ovf = 0; m_busy = 0; m_mode = 0;
    end else begin
      int cur;
      int cap;
      cur = vld ? imin(sc(re), sc(im)) : 15;
      if (ps) m_min = cur;
      else m_min = imin(m_min, cur);
      m_done = 0;
      if (ps && fst) begin
        m_busy = 1; m_mode = mode; m_total = 0; m_shift = 0; m_ovf = 0;
      end else if (m_busy && ovf && !m_mode) m_ovf = 1;
      if (pe && m_busy) begin
        if (lst) begin
          m_done = 1; m_busy = 0;
          m_exp = m_ovf ? 15 : m_total;
        end else begin
          cap = m_mode ? 15 : 14;
          m_shift = imin(imin(m_min, 4), cap - m_total);
          m_total += m_shift;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      check("R3/R4 shift_o", shift_o, m_shift);
      check("R5/R6 exp_o", exp_o, m_exp);
      check("R5 done_o", done_o, m_done);
      check("R6/R7 ovf_o", ovf_o, m_ovf);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input bit s, input bit f, input bit e, input bit l,
                     input bit v, input logic [15:0] r, input logic [15:0] i, input bit o);
    @(negedge clk);
    ps = s; fst = f; pe = e; lst = l; vld = v; re = r; im = i; ovf = o;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 16'h0, 16'h0, 0);
  endtask

  task automatic pend(input bit l, input int exp_shift, input string tag);
    cyc(0, 0, 1, l, 0, 16'h0, 16'h0, 0);
    idle();
    if (!l) check(tag, shift_o, exp_shift);
  endtask

  task automatic fin(input int e, input bit o, input string tag);
    cyc(0, 0, 1, 1, 0, 16'h0, 16'h0, 0);
    idle();
    check({tag, " done"}, done_o, 1);
    check({tag, " exp"}, exp_o, e);
    check({tag, " ovf"}, ovf_o, o);
    idle();
    check("R5 done one cycle", done_o, 0);
    check("R5 exp held", exp_o, e);
  endtask

  task automatic empty_pass(input bit f);
    cyc(1, f, 0, 0, 0, 16'h0, 16'h0, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 shift", shift_o, 0);
    check("R1 exp", exp_o, 0);
    check("R1 done", done_o, 0);
    check("R1 ovf", ovf_o, 0);
    rst_ni = 1'b1;
    idle();

    // T1: 3-bit mode, mixed data
    mode = 1'b1;
    cyc(1, 1, 0, 0, 0, 16'h0, 16'h0, 0);
    check("R3 first start", shift_o, 0);
    cyc(0, 0, 0, 0, 1, 16'd100, 16'hFFCE, 0);
    cyc(0, 0, 0, 0, 1, 16'h0, 16'd8191, 0);     // imag sets min = 2
    pend(0, 2, "R2 imag min");
    cyc(1, 0, 0, 0, 1, 16'd3, 16'hFFFC, 0);
    cyc(0, 0, 0, 0, 0, 16'h7FFF, 16'h8000, 0);  // not valid: ignored
    cyc(0, 0, 0, 0, 1, 16'd2, 16'd1, 0);
    pend(0, 4, "R2 invalid ignored / R3 per-pass cap");
    cyc(1, 0, 0, 0, 0, 16'h0, 16'h0, 0);
    cyc(0, 0, 0, 0, 1, 16'hB1E0, 16'd5, 0);     // -20000: count 0
    pend(0, 0, "R2 real min / R3");
    empty_pass(0);
    fin(6, 0, "R5 total 2+4+0");

    // T2: 3-bit mode, empty passes hit cap 15
    mode = 1'b1;
    empty_pass(1);
    pend(0, 4, "R8 empty pass");
    empty_pass(0); pend(0, 4, "R3");
    empty_pass(0); pend(0, 4, "R3");
    empty_pass(0); pend(0, 3, "R4 budget 15");
    empty_pass(0); pend(0, 0, "R4 budget used");
    empty_pass(0);
    fin(15, 0, "R4 cap 15");

    // T3: 2-bit mode caps at 14
    mode = 1'b0;
    empty_pass(1);
    pend(0, 4, "R8");
    empty_pass(0); pend(0, 4, "R3");
    empty_pass(0); pend(0, 4, "R3");
    empty_pass(0); pend(0, 2, "R4 budget 14");
    empty_pass(0); pend(0, 0, "R4 budget used");
    empty_pass(0);
    fin(14, 0, "R4 cap 14");

    // T4: 2-bit mode with overflow
    mode = 1'b0;
    empty_pass(1);
    pend(0, 4, "R8");
    cyc(1, 0, 0, 0, 0, 16'h0, 16'h0, 0);
    cyc(0, 0, 0, 0, 1, 16'd1000, 16'd7, 1);
    idle();
    check("R6 ovf flag", ovf_o, 1);
    pend(0, 4, "R3");
    empty_pass(0);
    fin(15, 1, "R6 overflow code");

    // T5: 3-bit mode ignores overflow; first start clears flag
    mode = 1'b1;
    cyc(1, 1, 0, 0, 0, 16'h0, 16'h0, 1);
    idle();
    check("R6 flag cleared", ovf_o, 0);
    cyc(0, 0, 0, 0, 1, 16'd4000, 16'd0, 1);
    idle();
    check("R7 ovf ignored", ovf_o, 0);
    pend(0, 3, "R2");
    empty_pass(0);
    fin(3, 0, "R7 exponent kept");

    repeat (3) idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule